// File: doc/BRIEF.md
# Multi-Format Byte Display Register

This block captures one byte from a shared 8-bit data bus and holds it for display. A load strobe, sampled on the rising clock edge, takes the bus value into a holding register. The value then stays on show until the next load or a synchronous clear. The raw byte drives a row of eight LEDs directly, one LED per bit.

The same held byte also drives a three-digit numeric readout with a separate minus indicator. A 2-bit format select picks how the byte is rendered: unsigned decimal, signed two's-complement decimal, or two hexadecimal digits. The fourth select code turns the readout off. The format select acts combinationally on the held value, so switching formats never disturbs the stored byte. Segment decoding, digit multiplexing and LED drive circuits sit outside this block.

Each digit output is a 5-bit code. Bit 4 set means the digit is dark, and the code for a dark digit is exactly 5'h10. Otherwise bit 4 is clear and bits 3:0 hold the digit value, 0 to 15. Digits are ordered from most significant (`dig_hi`) through `dig_mid` to least significant (`dig_lo`).

Top module: `byte_view_display`

## Requirements
- R1: On a rising clock edge with `srst` low and `load` high, the held byte becomes the value of `bus_in` at that edge.
- R2: On a rising clock edge with both `srst` and `load` low, the held byte keeps its value.
- R3: On a rising clock edge with `srst` high, the held byte becomes 0, whatever `load` and `bus_in` are.
- R4: `led_row` always equals the held byte, with bit i driving LED i.
- R5: With `fmt` = 2'b00 the held byte is shown as unsigned decimal 0 to 255 and `minus_on` is low.
- R6: With `fmt` = 2'b01 the held byte is read as two's complement. The magnitude is shown in decimal, covering -128 to 127, and `minus_on` is high exactly when bit 7 is set.
- R7: In both decimal formats, leading zero digits are dark (code 5'h10). A value of zero shows a single 0 in `dig_lo`.
- R8: With `fmt` = 2'b10, `dig_hi` is dark and `dig_mid`/`dig_lo` show the upper/lower nibble as values 0 to 15, with no zero suppression (00 to FF). `minus_on` is low.
- R9: With `fmt` = 2'b11, all three digits are dark and `minus_on` is low.
- R10: Changing `fmt` changes only the readout. The held byte, seen on `led_row`, is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear of the held byte; wins over load |
| load | input | 1 | Capture strobe for `bus_in` |
| bus_in | input | 8 | Shared data bus |
| fmt | input | 2 | Format select: 00 unsigned, 01 signed, 10 hex, 11 off |
| led_row | output | 8 | Held byte for the binary LED row |
| dig_hi | output | 5 | Hundreds digit code (dark in hex) |
| dig_mid | output | 5 | Tens digit or upper nibble code |
| dig_lo | output | 5 | Ones digit or lower nibble code |
| minus_on | output | 1 | Minus indicator for negative signed values |

## Verification
Clear and load can both be asserted at the same edge, with a nonzero byte on the bus. The bench provokes this collision both in directed cases and from random draws. It then expects a held value of zero on `led_row` and a readout of a single 0 in the decimal formats. A format change in the same cycle as a load is also covered. Here the readout must show the new byte in the new format, and no stale mix of the two.

// File: rtl/byte_view_display.sv
module byte_view_display #(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          load,
  input  logic [DW-1:0] bus_in,
  input  logic [1:0]    fmt,
  output logic [DW-1:0] led_row,
  output logic [CW-1:0] dig_hi,
  output logic [CW-1:0] dig_mid,
  output logic [CW-1:0] dig_lo,
  output logic          minus_on
);
  localparam logic [1:0] FMT_UNS = 2'b00;
  localparam logic [1:0] FMT_SGN = 2'b01;
  localparam logic [1:0] FMT_HEX = 2'b10;
  localparam logic [CW-1:0] DARK = CW'(1) << (CW-1);

  logic [DW-1:0] held;
  logic [DW-1:0] mag;
  logic [3:0]    hund, tens, ones;
  logic          neg;

  always_ff @(posedge clk) begin
    if (srst)      held <= '0;
    else if (load) held <= bus_in;
  end

  assign led_row = held;
  assign neg     = (fmt == FMT_SGN) && held[DW-1];
  assign mag     = neg ? (~held + 1'b1) : held;
  assign hund    = 4'(mag / 100);
  assign tens    = 4'((mag / 10) % 10);
  assign ones    = 4'(mag % 10);

  always_comb begin
    dig_hi   = DARK;
    dig_mid  = DARK;
    dig_lo   = DARK;
    minus_on = 1'b0;
    case (fmt)
      FMT_UNS, FMT_SGN: begin
        minus_on = neg;
        dig_lo   = {1'b0, ones};
        if (hund != 0) begin
          dig_hi  = {1'b0, hund};
          dig_mid = {1'b0, tens};
        end else if (tens != 0) begin
          dig_mid = {1'b0, tens};
        end
      end
      FMT_HEX: begin
        dig_mid = {1'b0, held[DW-1 -: 4]};
        dig_lo  = {1'b0, held[3:0]};
      end
      default: ;
    endcase
  end

  logic primed = 1'b0;
  always_ff @(posedge clk) if (srst) primed <= 1'b1;

  // R3
  clear_zero_chk: assert property (@(posedge clk) primed && $past(srst) |-> led_row == '0);
  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (srst || !primed)
    load |=> led_row == $past(bus_in));
  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (srst || !primed)
    !load |=> $stable(led_row));
  // R9
  blank_mode_chk: assert property (@(posedge clk) disable iff (!primed)
    fmt == 2'b11 |-> !minus_on && dig_hi == DARK && dig_mid == DARK && dig_lo == DARK);
  // R6
  minus_only_neg_chk: assert property (@(posedge clk) disable iff (!primed)
    minus_on |-> fmt == FMT_SGN && led_row[DW-1]);
  // R7
  zero_suppress_chk: assert property (@(posedge clk) disable iff (!primed)
    fmt[1] == 1'b0 && dig_hi == DARK |-> dig_lo != DARK);
endmodule

// File: tb/byte_view_display_tb_top.sv
`timescale 1ns/100ps
module byte_view_display_tb_top;
  logic clk = 1'b0;
  logic srst, load;
  logic [7:0] bus_in;
  logic [1:0] fmt;
  logic [7:0] led_row;
  logic [4:0] dig_hi, dig_mid, dig_lo;
  logic minus_on;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  byte_view_display dut_i (.clk, .srst, .load, .bus_in, .fmt, .led_row,
    .dig_hi, .dig_mid, .dig_lo, .minus_on);

  function automatic logic [15:0] expect_view(logic [7:0] b, logic [1:0] f);
    logic [4:0] h, m, l;
    logic mn;
    int v, c2, c1;
    h = 5'h10; m = 5'h10; l = 5'h10; mn = 1'b0;
    if (f == 2'b10) begin
      m = {1'b0, b[7:4]}; l = {1'b0, b[3:0]};
    end else if (f != 2'b11) begin
      v = b;
      if (f == 2'b01 && b >= 128) begin v = 256 - b; mn = 1'b1; end
      c2 = 0; while (v >= 100) begin v -= 100; c2++; end
      c1 = 0; while (v >= 10) begin v -= 10; c1++; end
      l = 5'(v);
      if (c2 > 0) begin h = 5'(c2); m = 5'(c1); end
      else if (c1 > 0) m = 5'(c1);
    end
    return {mn, h, m, l};
  endfunction

  task automatic check(string tag);
    logic [15:0] got, exp;
    got = {minus_on, dig_hi, dig_mid, dig_lo};
    exp = expect_view(model, fmt);
    checks++;
    if (led_row !== model) begin
      errors++;
      $display("FAIL %s led_row got=%h exp=%h", tag, led_row, model);
    end
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s view fmt=%b byte=%h got=%h exp=%h", tag, fmt, model, got, exp);
    end
  endtask

  task automatic step(logic c, logic ld, logic [7:0] d, logic [1:0] f);
    @(negedge clk);
    srst = c; load = ld; bus_in = d; fmt = f;
    @(posedge clk);
    if (c) model = 8'h00; else if (ld) model = d;
    #1;
  endtask

  task automatic all_fmts(logic [7:0] d, string tag);
    step(1'b0, 1'b1, d, 2'b00); check(tag);
    for (int f = 1; f < 4; f++) begin
      step(1'b0, 1'b0, 8'h5A, 2'(f)); check(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    srst = 1'b1; load = 1'b0; bus_in = 8'h00; fmt = 2'b00; model = 8'h00;
    @(posedge clk); #1;
    check("R3_reset");
    all_fmts(8'd0,   "R7_zero");
    all_fmts(8'd5,   "R7_one_digit");
    all_fmts(8'd10,  "R7_two_digit");
    all_fmts(8'd100, "R5_hundred");
    all_fmts(8'd255, "R5_R6_max");
    all_fmts(8'd128, "R6_min_neg");
    all_fmts(8'd127, "R6_max_pos");
    all_fmts(8'hA0,  "R8_hex_nibbles");
    step(1'b0, 1'b0, 8'h33, 2'b00); check("R2_hold");
    step(1'b0, 1'b0, 8'h33, 2'b11); check("R9_blank");
    step(1'b0, 1'b0, 8'h33, 2'b01); check("R10_fmt_keeps_byte");
    step(1'b1, 1'b1, 8'hF7, 2'b01); check("R3_clear_beats_load");
    step(1'b0, 1'b1, 8'h9C, 2'b10); check("R1_load_with_fmt_change");
    for (int i = 0; i < 600; i++) begin
      logic c;
      c = ($urandom % 16) == 0;
      step(c, 1'($urandom), 8'($urandom), 2'($urandom));
      check(c ? "R3_rand" : "R1_R2_R4_rand");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule